// File: doc/BRIEF.md
# Eight-Entry Wraparound Register Stack

This block is a last-in first-out stack of eight 80-bit registers, addressed relative to the current top. An operation code selects one of four actions. Idle leaves the stack alone. Push places a new value on top. Pop discards the top. Add takes the top two values, replaces both with their sum, and finishes in one clock. One combinational read port returns the entry at a given depth below the top, and it flags a depth that holds no valid entry.

The stack never stalls. When all eight slots are valid, a push overwrites the oldest entry without any signal, and the stack keeps the newest eight values. The physical slots form a ring that a 3-bit top pointer walks modulo eight, so no data moves on a push or a pop. A pop or add that lacks operands is refused. A combinational strobe reports the refusal and the state does not change. The add is a plain 80-bit integer sum that wraps modulo 2^80. It stands in for a wider arithmetic unit.

Top module: `wrap_stack`

## Requirements
- R1: After reset, the stack holds no valid entries, and a read at any depth 0 to 7 gives rd_empty_o = 1.
- R2: Operation code 2'b01 (push) makes push_data_i readable at depth 0 from the next cycle. Every earlier entry moves one depth deeper.
- R3: Operation code 2'b10 (pop), with at least one entry valid, removes the depth-0 entry. Each remaining entry moves one depth shallower and the occupancy drops by one.
- R4: A push while all eight entries are valid discards the entry at depth 7 and keeps the occupancy at eight. The seven newer entries move to depths 1 to 7.
- R5: Operation code 2'b11 (add), with at least two entries valid, replaces depths 0 and 1 in one clock by their sum modulo 2^80 at depth 0. Deeper entries move up one and the occupancy drops by one.
- R6: A pop with no valid entry, or an add with fewer than two, raises underflow_o in the same cycle and changes neither contents nor occupancy.
- R7: rd_empty_o is high exactly when rd_idx_i is at or above the occupancy. Otherwise rd_data_o shows the entry at that depth in the same cycle.
- R8: Operation code 2'b00 (idle) changes neither contents nor occupancy.

Top module ports below; occupancy is observed through rd_empty_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 2 | 00 idle, 01 push, 10 pop, 11 add |
| push_data_i | input | 80 | Value written by a push |
| rd_idx_i | input | 3 | Read depth, 0 is the top |
| rd_data_o | output | 80 | Entry at depth rd_idx_i |
| rd_empty_o | output | 1 | Depth rd_idx_i holds no valid entry |
| underflow_o | output | 1 | Pop or add refused for lack of operands |

## Verification
The assertions assume that op_i and rd_idx_i are stable and defined at each rising edge. They also assume that a depth-0 read in the cycle after a push shows that push's value. The bench changes every input only on the falling edge, and it samples outputs one time unit after an edge. Random operation mixes bias toward push, so the stack fills and overflows often. Directed runs drain the stack to empty and then request further pops and adds, so every operation meets every occupancy level, including the refusal cases.

// File: rtl/wstk_pkg.sv
package wstk_pkg;
  typedef enum logic [1:0] {
    OP_IDLE = 2'b00,
    OP_PUSH = 2'b01,
    OP_POP  = 2'b10,
    OP_ADD  = 2'b11
  } stk_op_e;
endpackage

// File: rtl/wstk_ctrl.sv
module wstk_ctrl #(
  parameter int DEPTH = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       op_i,
  output logic [PTR_W-1:0] top_q_o,
  output logic [CNT_W-1:0] cnt_q_o,
  output logic             underflow_o,
  output logic             wr_en_o,
  output logic [PTR_W-1:0] wr_ptr_o,
  output logic             wr_sum_o
);
  import wstk_pkg::*;

  logic [PTR_W-1:0] top_q, top_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  stk_op_e op;

  assign op = stk_op_e'(op_i);

  always_comb begin
    top_d       = top_q;
    cnt_d       = cnt_q;
    underflow_o = 1'b0;
    wr_en_o     = 1'b0;
    wr_ptr_o    = top_q;
    wr_sum_o    = 1'b0;
    unique case (op)
      OP_PUSH: begin
        top_d    = top_q - 1'b1;
        wr_en_o  = 1'b1;
        wr_ptr_o = top_q - 1'b1;
        // full: slot below top is the oldest, overwritten in place
        if (cnt_q != CNT_W'(DEPTH)) cnt_d = cnt_q + 1'b1;
      end
      OP_POP: begin
        if (cnt_q == '0) underflow_o = 1'b1;
        else begin
          top_d = top_q + 1'b1;
          cnt_d = cnt_q - 1'b1;
        end
      end
      OP_ADD: begin
        if (cnt_q < CNT_W'(2)) underflow_o = 1'b1;
        else begin
          top_d    = top_q + 1'b1;
          cnt_d    = cnt_q - 1'b1;
          wr_en_o  = 1'b1;
          wr_ptr_o = top_q + 1'b1;
          wr_sum_o = 1'b1;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      top_q <= '0;
      cnt_q <= '0;
    end else begin
      top_q <= top_d;
      cnt_q <= cnt_d;
    end
  end

  assign top_q_o = top_q;
  assign cnt_q_o = cnt_q;
endmodule

// File: rtl/wstk_rf.sv
module wstk_rf #(
  parameter int DATA_W = 80,
  parameter int DEPTH  = 8,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [PTR_W-1:0]  wr_ptr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [PTR_W-1:0]  rd_ptr_i,
  input  logic [PTR_W-1:0]  opa_ptr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [DATA_W-1:0] opa_o,
  output logic [DATA_W-1:0] opb_o
);
  logic [DATA_W-1:0] slot_q [DEPTH];
  logic [PTR_W-1:0]  opb_ptr;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) slot_q[g] <= '0;
      else if (wr_en_i && wr_ptr_i == PTR_W'(g)) slot_q[g] <= wr_data_i;
    end
  end

  assign opb_ptr   = opa_ptr_i + 1'b1;
  assign rd_data_o = slot_q[rd_ptr_i];
  assign opa_o     = slot_q[opa_ptr_i];
  assign opb_o     = slot_q[opb_ptr];
endmodule

// File: rtl/wstk_adder.sv
module wstk_adder #(
  parameter int DATA_W = 80
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] sum_o
);
  assign sum_o = a_i + b_i;
endmodule

// File: rtl/wrap_stack.sv
module wrap_stack #(
  parameter int DATA_W = 80,
  parameter int DEPTH  = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        op_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic [PTR_W-1:0]  rd_idx_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_empty_o,
  output logic              underflow_o
);
  logic [PTR_W-1:0]  top_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              wr_en, wr_sum;
  logic [PTR_W-1:0]  wr_ptr;
  logic [DATA_W-1:0] opa, opb, sum, wr_data;

  wstk_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk_i, .rst_ni, .op_i,
    .top_q_o(top_q), .cnt_q_o(cnt_q), .underflow_o,
    .wr_en_o(wr_en), .wr_ptr_o(wr_ptr), .wr_sum_o(wr_sum)
  );

  wstk_adder #(.DATA_W(DATA_W)) u_add (.a_i(opa), .b_i(opb), .sum_o(sum));

  assign wr_data = wr_sum ? sum : push_data_i;

  wstk_rf #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_rf (
    .clk_i, .rst_ni,
    .wr_en_i(wr_en), .wr_ptr_i(wr_ptr), .wr_data_i(wr_data),
    .rd_ptr_i(top_q + rd_idx_i), .opa_ptr_i(top_q),
    .rd_data_o, .opa_o(opa), .opb_o(opb)
  );

  assign rd_empty_o = CNT_W'(rd_idx_i) >= cnt_q;
endmodule

// File: rtl/wstk_chk.sv
module wstk_chk #(
  parameter int DATA_W = 80,
  parameter int DEPTH  = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [1:0]        op_i,
  input logic [DATA_W-1:0] push_data_i,
  input logic [PTR_W-1:0]  rd_idx_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              rd_empty_o,
  input logic              underflow_o,
  input logic [PTR_W-1:0]  top_q,
  input logic [CNT_W-1:0]  cnt_q
);
  assert_empty_when_zero_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == '0) |-> rd_empty_o);

  assert_push_visible_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 2'b01) |=> (rd_idx_i != '0 || rd_data_o == $past(push_data_i)));

  assert_pop_count_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 2'b10 && !underflow_o) |=> cnt_q == $past(cnt_q) - 1'b1);

  assert_full_push_keeps_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 2'b01 && cnt_q == CNT_W'(DEPTH)) |=> cnt_q == CNT_W'(DEPTH));

  assert_no_overflow_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DEPTH));

  assert_add_count_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 2'b11 && !underflow_o) |=> cnt_q == $past(cnt_q) - 1'b1);

  assert_underflow_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underflow_o |=> ($stable(cnt_q) && $stable(top_q)));

  assert_top_valid_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_idx_i == '0 && cnt_q != '0) |-> !rd_empty_o);

  assert_idle_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 2'b00) |=> ($stable(cnt_q) && $stable(top_q)));
endmodule

bind wrap_stack wstk_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
  .clk_i, .rst_ni, .op_i, .push_data_i, .rd_idx_i,
  .rd_data_o, .rd_empty_o, .underflow_o, .top_q, .cnt_q
);

// File: tb/wrap_stack_bench.sv
module wrap_stack_bench;
  localparam int CLK_P = 10;
  localparam logic [1:0] IDLE = 2'b00, PUSH = 2'b01, POP = 2'b10, ADD = 2'b11;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  op = IDLE;
  logic [79:0] pdata = '0;
  logic [2:0]  idx = '0;
  logic [79:0] rd_data;
  logic        rd_empty, uflow;

  int checks = 0;
  int fails  = 0;

  logic [79:0] mdl [8];
  int          mcnt = 0;

  always #(CLK_P/2) clk = ~clk;

  wrap_stack u_wrap_stack (
    .clk_i(clk), .rst_ni(rst_n), .op_i(op), .push_data_i(pdata),
    .rd_idx_i(idx), .rd_data_o(rd_data), .rd_empty_o(rd_empty), .underflow_o(uflow)
  );

  task automatic chk(input bit ok, input string req, input logic [79:0] act, input logic [79:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic bit exp_uflow(input logic [1:0] o, input int c);
    return (o == POP && c == 0) || (o == ADD && c < 2);
  endfunction

  task automatic model_update(input logic [1:0] o, input logic [79:0] d);
    logic [79:0] s;
    case (o)
      PUSH: begin
        for (int i = 7; i > 0; i--) mdl[i] = mdl[i-1];
        mdl[0] = d;
        if (mcnt < 8) mcnt++;
      end
      POP: begin
        for (int i = 0; i < 7; i++) mdl[i] = mdl[i+1];
        mcnt--;
      end
      ADD: begin
        s = mdl[0] + mdl[1];
        for (int i = 0; i < 7; i++) mdl[i] = mdl[i+1];
        mdl[0] = s;
        mcnt--;
      end
      default: ;
    endcase
  endtask

  task automatic check_read(input string req);
    bit e;
    e = int'(idx) >= mcnt;
    chk(rd_empty == e, "R7 empty flag", 80'(rd_empty), 80'(e));
    if (!e) chk(rd_data == mdl[idx], req, rd_data, mdl[idx]);
  endtask

  task automatic step(input logic [1:0] o, input logic [79:0] d, input logic [2:0] ix);
    bit u;
    string req;
    @(negedge clk);
    op = o; pdata = d; idx = ix;
    #1;
    u = exp_uflow(o, mcnt);
    chk(uflow == u, "R6 underflow strobe", 80'(uflow), 80'(u));
    check_read("R7 read before edge");
    if (u) req = "R6 state held";
    else if (o == PUSH && mcnt == 8) req = "R4 full push";
    else if (o == PUSH) req = "R2 push";
    else if (o == POP) req = "R3 pop";
    else if (o == ADD) req = "R5 add";
    else req = "R8 idle";
    @(posedge clk);
    if (!u) model_update(o, d);
    #1;
    check_read(req);
  endtask

  function automatic logic [79:0] rnd80();
    return {$urandom(), $urandom(), $urandom()};
  endfunction

  initial begin
    #(CLK_P * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [1:0] o;
    int r;
    void'($urandom(32'd1234));
    for (int i = 0; i < 8; i++) mdl[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      idx = 3'(k);
      #1;
      chk(rd_empty == 1'b1, "R1 empty after reset", 80'(rd_empty), 80'(1));
    end
    // refusals on empty and single-entry stacks
    step(POP, '0, 0);
    step(ADD, '0, 0);
    step(PUSH, 80'h1, 0);
    step(ADD, '0, 0);
    // sum wraps modulo 2^80
    step(PUSH, {80{1'b1}}, 1);
    step(ADD, '0, 0);
    chk(rd_data == '0, "R5 wrap sum", rd_data, '0);
    step(IDLE, '0, 0);
    step(POP, '0, 0);
    step(POP, '0, 0);
    // overfill: ten pushes, oldest two lost
    for (int k = 0; k < 10; k++) step(PUSH, 80'(100 + k), 3'(k % 8));
    for (int k = 0; k < 8; k++) begin
      step(IDLE, '0, 3'(k));
      chk(rd_data == 80'(109 - k), "R4 newest eight kept", rd_data, 80'(109 - k));
    end
    for (int k = 0; k < 9; k++) step(POP, '0, 0);
    // random mix
    for (int n = 0; n < 3000; n++) begin
      r = int'($urandom_range(0, 99));
      if (r < 40) o = PUSH;
      else if (r < 65) o = POP;
      else if (r < 90) o = ADD;
      else o = IDLE;
      step(o, rnd80(), 3'($urandom_range(0, 7)));
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule